// File: doc/BRIEF.md
# Vector Memory Address Sequencer

This block turns one vector memory instruction into a stream of element addresses. A single start pulse captures a mode, a base address, a stride or scalar operand and a requested element count. After a fixed startup delay the block presents one element per clock on a valid/ready output, and it raises a one-cycle completion pulse once the final element has been taken.

There are four modes. Unit mode walks consecutive 8-byte doublewords from the base. Strided mode adds the element number times a programmable stride to the base. Indexed mode (gather/scatter) adds the base to an offset. It takes that offset from an index vector register through a read port, which the block drives with the element number. Create mode produces no memory address. It emits the sequence 0, s, 2s, and so on, for writing into a destination vector register, and flags each beat so the consumer can tell the two cases apart.

The element count is limited to one vector register, 64 elements by default. A larger request is cut down to that limit. A request of zero finishes at once.

Top module: `vec_agen`

## Requirements
- R1: After reset, out_valid, busy and done are all low.
- R2: When start is seen while idle with a nonzero length, busy rises on that edge. The first beat (element 0) appears on out_valid exactly STARTUP (default 12) clock edges after that edge.
- R3: Mode code 0 (unit): element i has out_addr = base + 8*i.
- R4: Mode code 1 (strided): element i has out_addr = base + i*stride, modulo 2^AW.
- R5: Mode code 2 (indexed): idx_rd_addr carries the element number being formed, and element i has out_addr = base + idx_rd_data read for element i.
- R6: Mode code 3 (create): element i has out_addr = i*stride, base has no effect, and out_create is high on every beat.
- R7: While out_valid is high and out_ready is low, out_valid, out_addr and out_elem keep their values on the next cycle.
- R8: With out_ready held high, beats follow on consecutive cycles with out_elem counting 0, 1, 2, ... with no gaps.
- R9: done is high for exactly one cycle, on the cycle after the last beat is accepted, and busy is low in that same cycle.
- R10: A length of zero issues no beat, and done pulses on the cycle after the start edge.
- R11: A length above MAXVL (default 64) yields exactly MAXVL beats.
- R12: A start pulse while busy is ignored: the running sequence carries on unchanged, and no second sequence follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a sequence (taken only when idle) |
| mode | input | 2 | 0 unit, 1 strided, 2 indexed, 3 create |
| base | input | AW | Base byte address |
| stride | input | AW | Stride in bytes, or scalar step in create mode |
| vlen | input | LW | Requested element count |
| idx_rd_addr | output | EW | Element number for the index register read |
| idx_rd_data | input | DW | Index element returned in the same cycle |
| out_valid | output | 1 | Beat present |
| out_ready | input | 1 | Consumer takes the beat |
| out_addr | output | AW | Element address, or created value |
| out_elem | output | EW | Element number of the beat |
| out_create | output | 1 | Beat is a created index value, not an address |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that idx_rd_data answers the idx_rd_addr of the same cycle. They also assume that mode, base, stride and vlen matter only on the start edge. The bench meets the first assumption by driving the index data combinationally from a fixed table. It changes the instruction fields only when it drives start.

The consumer side is unconstrained. out_ready is driven both steady high and with a pseudo-random pattern, so the hold and step properties see stalls at every stage of a run, including on the last beat.

// File: rtl/vagen_pkg.sv
package vagen_pkg;

   typedef enum logic [1:0] {
      AG_UNIT   = 2'd0,
      AG_STRIDE = 2'd1,
      AG_INDEX  = 2'd2,
      AG_CREATE = 2'd3
   } ag_mode_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WAIT = 2'd1,
      ST_RUN  = 2'd2
   } ag_state_e;

endpackage

// File: rtl/vagen_len_clamp.sv
module vagen_len_clamp #(
   parameter int LW    = 8,
   parameter int MAXVL = 64,
   parameter int CW    = $clog2(MAXVL + 1)
) (
   input  logic [LW-1:0] req_len,
   output logic [CW-1:0] eff_len
);
   localparam longint REQ_MAX = (longint'(1) << LW) - 1;

   generate
      if (REQ_MAX <= MAXVL) begin : g_direct
         // the request can never exceed the register size
         assign eff_len = CW'(req_len);
      end else begin : g_limit
         assign eff_len = (req_len > LW'(MAXVL)) ? CW'(MAXVL) : CW'(req_len);
      end
   endgenerate
endmodule

// File: rtl/vagen_startup.sv
module vagen_startup #(
   parameter int STARTUP = 12,
   parameter int SW      = $clog2(STARTUP + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   output logic expire
);
   logic [SW-1:0] cnt;

   // arm loads STARTUP-1; expire fires when one count remains, so the
   // first load happens exactly STARTUP edges after the arming edge
   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt <= '0;
      else if (arm)
         cnt <= SW'(STARTUP - 1);
      else if (cnt != '0)
         cnt <= cnt - 1'b1;
   end

   assign expire = (cnt == SW'(1));
endmodule

// File: rtl/vagen_elem_gen.sv
module vagen_elem_gen
   import vagen_pkg::*;
#(
   parameter int AW         = 64,
   parameter int DW         = 64,
   parameter int ELEM_BYTES = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          init,
   input  logic          step,
   input  ag_mode_e      mode,
   input  logic [AW-1:0] base,
   input  logic [AW-1:0] stride,
   input  logic [DW-1:0] idx_data,
   output logic [AW-1:0] value
);
   logic [AW-1:0] pitch;
   logic [AW-1:0] offs;
   logic [AW-1:0] idx_ext;

   always_comb pitch = (mode == AG_UNIT) ? AW'(ELEM_BYTES) : stride;

   // running product: offs always equals element number times pitch
   always_ff @(posedge clk) begin
      if (!rst_n)
         offs <= '0;
      else if (init)
         offs <= '0;
      else if (step)
         offs <= offs + pitch;
   end

   generate
      if (DW >= AW) begin : g_idx_trunc
         assign idx_ext = idx_data[AW-1:0];
      end else begin : g_idx_zext
         assign idx_ext = {{(AW-DW){1'b0}}, idx_data};
      end
   endgenerate

   always_comb begin
      unique case (mode)
         AG_INDEX:  value = base + idx_ext;
         AG_CREATE: value = offs;
         default:   value = base + offs;
      endcase
   end
endmodule

// File: rtl/vec_agen.sv
module vec_agen
   import vagen_pkg::*;
#(
   parameter int AW         = 64,
   parameter int DW         = 64,
   parameter int LW         = 8,
   parameter int MAXVL      = 64,
   parameter int STARTUP    = 12,
   parameter int ELEM_BYTES = 8,
   localparam int EW        = $clog2(MAXVL),
   localparam int CW        = $clog2(MAXVL + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [1:0]    mode,
   input  logic [AW-1:0] base,
   input  logic [AW-1:0] stride,
   input  logic [LW-1:0] vlen,
   output logic [EW-1:0] idx_rd_addr,
   input  logic [DW-1:0] idx_rd_data,
   output logic          out_valid,
   input  logic          out_ready,
   output logic [AW-1:0] out_addr,
   output logic [EW-1:0] out_elem,
   output logic          out_create,
   output logic          busy,
   output logic          done
);
   generate
      if (STARTUP < 2) begin : g_bad_startup
         $error("vec_agen: STARTUP must be at least 2");
      end
      if (MAXVL < 2) begin : g_bad_maxvl
         $error("vec_agen: MAXVL must be at least 2");
      end
      if (ELEM_BYTES < 1) begin : g_bad_elem
         $error("vec_agen: ELEM_BYTES must be positive");
      end
   endgenerate

   ag_state_e     state;
   ag_mode_e      cap_mode;
   logic [AW-1:0] cap_base;
   logic [AW-1:0] cap_stride;
   logic [CW-1:0] cap_len;
   logic [CW-1:0] gen_idx;
   logic [CW-1:0] req_len;
   logic [AW-1:0] elem_value;
   logic          accept;
   logic          can_load;
   logic          expire;

   vagen_len_clamp #(.LW(LW), .MAXVL(MAXVL), .CW(CW)) u_clamp (
      .req_len (vlen),
      .eff_len (req_len)
   );

   vagen_startup #(.STARTUP(STARTUP)) u_startup (
      .clk    (clk),
      .rst_n  (rst_n),
      .arm    (accept && (req_len != '0)),
      .expire (expire)
   );

   vagen_elem_gen #(.AW(AW), .DW(DW), .ELEM_BYTES(ELEM_BYTES)) u_elem (
      .clk      (clk),
      .rst_n    (rst_n),
      .init     (accept),
      .step     (can_load),
      .mode     (cap_mode),
      .base     (cap_base),
      .stride   (cap_stride),
      .idx_data (idx_rd_data),
      .value    (elem_value)
   );

   assign accept      = start && (state == ST_IDLE);
   assign can_load    = (state == ST_RUN) && (gen_idx < cap_len) &&
                        (!out_valid || out_ready);
   assign idx_rd_addr = gen_idx[EW-1:0];
   assign busy        = (state != ST_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         cap_mode   <= AG_UNIT;
         cap_base   <= '0;
         cap_stride <= '0;
         cap_len    <= '0;
         gen_idx    <= '0;
         out_valid  <= 1'b0;
         out_addr   <= '0;
         out_elem   <= '0;
         out_create <= 1'b0;
         done       <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (start) begin
                  cap_mode   <= ag_mode_e'(mode);
                  cap_base   <= base;
                  cap_stride <= stride;
                  cap_len    <= req_len;
                  gen_idx    <= '0;
                  if (req_len == '0)
                     done <= 1'b1;
                  else
                     state <= ST_WAIT;
               end
            end
            ST_WAIT: begin
               if (expire)
                  state <= ST_RUN;
            end
            ST_RUN: begin
               if (can_load) begin
                  out_valid  <= 1'b1;
                  out_addr   <= elem_value;
                  out_elem   <= gen_idx[EW-1:0];
                  out_create <= (cap_mode == AG_CREATE);
                  gen_idx    <= gen_idx + 1'b1;
               end else if (out_valid && out_ready) begin
                  out_valid <= 1'b0;
                  done      <= 1'b1;
                  state     <= ST_IDLE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/vec_agen_chk.sv
module vec_agen_chk #(
   parameter int AW = 64,
   parameter int EW = 6
) (
   input logic          clk,
   input logic          rst_n,
   input logic          busy,
   input logic          out_valid,
   input logic          out_ready,
   input logic [AW-1:0] out_addr,
   input logic [EW-1:0] out_elem,
   input logic          done
);
   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !out_valid);

   assert_first_elem_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> (out_elem == '0));

   assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=>
         (out_valid && $stable(out_addr) && $stable(out_elem)));

   assert_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready) |=>
         (!out_valid || (out_elem == EW'($past(out_elem) + 1'b1))));

   assert_done_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && !out_valid));

   assert_busy_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !(out_valid && out_ready)) |=> busy);
endmodule

bind vec_agen vec_agen_chk #(.AW(AW), .EW(EW)) u_vec_agen_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .busy      (busy),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_addr  (out_addr),
   .out_elem  (out_elem),
   .done      (done)
);

// File: tb/tb_vec_agen.sv
module tb_vec_agen;
   localparam int STARTUP = 12;
   localparam int MAXVL   = 64;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [1:0]  mode = 2'd0;
   logic [63:0] base = '0;
   logic [63:0] stride = '0;
   logic [7:0]  vlen = '0;
   logic [5:0]  idx_rd_addr;
   logic [63:0] idx_rd_data;
   logic        out_valid;
   logic        out_ready = 1'b1;
   logic [63:0] out_addr;
   logic [5:0]  out_elem;
   logic        out_create;
   logic        busy;
   logic        done;

   logic [63:0] imem [MAXVL];
   assign idx_rd_data = imem[idx_rd_addr];

   vec_agen dut (
      .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .base(base),
      .stride(stride), .vlen(vlen), .idx_rd_addr(idx_rd_addr),
      .idx_rd_data(idx_rd_data), .out_valid(out_valid), .out_ready(out_ready),
      .out_addr(out_addr), .out_elem(out_elem), .out_create(out_create),
      .busy(busy), .done(done)
   );

   always #5 clk = ~clk;

   int    n_vec = 0;
   int    n_bad = 0;
   int    cyc = 0;
   string cur_req = "R1";
   bit    rdy_rand = 1'b0;
   bit    finished = 1'b0;

   // behavioural reference state
   bit          m_busy = 0, m_valid = 0, m_done = 0, m_create = 0;
   int          m_timer = 0, m_len = 0, m_next = 0, m_elem = 0;
   logic [63:0] m_addr = '0;
   logic [63:0] exp_q [$];
   int          acc_cnt = 0, done_cnt = 0;

   task automatic chk(input bit ok, input string what, input logic [63:0] act,
                      input logic [63:0] expv);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, expv);
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_busy = 0; m_valid = 0; m_done = 0; m_timer = 0;
      end else begin
         if (out_valid && out_ready) acc_cnt++;
         if (done) done_cnt++;
         m_done = 0;
         if (!m_busy) begin
            if (start) begin
               m_len = (vlen > MAXVL) ? MAXVL : int'(vlen);
               m_create = (mode == 2'd3);
               exp_q.delete();
               for (int i = 0; i < m_len; i++) begin
                  case (mode)
                     2'd0: exp_q.push_back(base + 64'(i) * 64'd8);
                     2'd1: exp_q.push_back(base + 64'(i) * stride);
                     2'd2: exp_q.push_back(base + imem[i]);
                     default: exp_q.push_back(64'(i) * stride);
                  endcase
               end
               if (m_len == 0) m_done = 1;
               else begin m_busy = 1; m_timer = STARTUP; m_next = 0; end
            end
         end else if (m_timer > 0) begin
            m_timer--;
            if (m_timer == 0) begin
               m_valid = 1; m_elem = 0; m_addr = exp_q[0]; m_next = 1;
            end
         end else if (m_valid && out_ready) begin
            if (m_next < m_len) begin
               m_elem = m_next; m_addr = exp_q[m_next]; m_next++;
            end else begin
               m_valid = 0; m_done = 1; m_busy = 0;
            end
         end
      end
   end

   // compare on every clock, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         chk(out_valid == m_valid, "out_valid", 64'(out_valid), 64'(m_valid));
         chk(busy == m_busy, "busy", 64'(busy), 64'(m_busy));
         chk(done == m_done, "done", 64'(done), 64'(m_done));
         if (m_valid) begin
            chk(out_addr == m_addr, "out_addr", out_addr, m_addr);
            chk(int'(out_elem) == m_elem, "out_elem", 64'(out_elem), 64'(m_elem));
            chk(out_create == m_create, "out_create", 64'(out_create), 64'(m_create));
         end
         if (rdy_rand) out_ready = ($urandom % 4) != 0;
         else          out_ready = 1'b1;
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !finished) begin
         finished = 1'b1;
         n_bad++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   task automatic run_op(input logic [1:0] md, input logic [63:0] b,
                         input logic [63:0] s, input logic [7:0] vl,
                         input bit rnd, input bit poke, input string tag);
      int expn;
      cur_req = tag;
      expn = (vl > MAXVL) ? MAXVL : int'(vl);
      @(negedge clk);
      rdy_rand = rnd;
      mode = md; base = b; stride = s; vlen = vl; start = 1'b1;
      acc_cnt = 0; done_cnt = 0;
      @(negedge clk);
      start = 1'b0;
      if (poke) begin
         // R12: a second start mid-run must be ignored
         repeat (5) @(negedge clk);
         mode = 2'd3; base = 64'hDEAD_0000; stride = 64'd3; vlen = 8'd2;
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      while (m_busy) @(negedge clk);
      repeat (4) @(negedge clk);
      chk(acc_cnt == expn, "beat count", 64'(acc_cnt), 64'(expn));
      cur_req = "R9";
      chk(done_cnt == 1, "done pulses", 64'(done_cnt), 64'd1);
      rdy_rand = 1'b0;
   endtask

   initial begin
      for (int i = 0; i < MAXVL; i++)
         imem[i] = 64'((i * 37) % 64) * 64'd8 + 64'h40;
      imem[5] = 64'hFFFF_FFFF_FFFF_FFF8;
      repeat (3) @(negedge clk);
      cur_req = "R1";
      chk(!out_valid && !busy && !done, "reset outputs",
          {61'd0, out_valid, busy, done}, 64'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      run_op(2'd0, 64'h1000, 64'h0, 8'd5, 1'b0, 1'b0, "R3");   // unit, R2, R8
      run_op(2'd1, 64'h2000, 64'd24, 8'd10, 1'b1, 1'b0, "R7"); // strided, stalls
      run_op(2'd1, 64'h8000, 64'hFFFF_FFFF_FFFF_FFF8, 8'd6, 1'b0, 1'b0, "R4");
      run_op(2'd2, 64'h4_0000, 64'h0, 8'd8, 1'b1, 1'b0, "R5");  // gather
      run_op(2'd3, 64'h7777, 64'd5, 8'd64, 1'b0, 1'b0, "R6");   // create
      run_op(2'd0, 64'h0, 64'h0, 8'd0, 1'b0, 1'b0, "R10");      // empty
      run_op(2'd0, 64'h100, 64'h0, 8'd200, 1'b1, 1'b0, "R11");  // clamp
      run_op(2'd1, 64'h500, 64'd16, 8'd20, 1'b0, 1'b1, "R12");  // ignored start
      run_op(2'd2, 64'h10, 64'h0, 8'd1, 1'b0, 1'b0, "R2");      // single beat

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule